// File: doc/BRIEF.md
# Load Instruction Control Sequencer

This block is the hardwired control unit for a processor whose registers, ALU and memory interface share one internal bus. It runs load-to-register instructions as a series of numbered control steps. In each step it raises the bus-source enables, register load enables, the memory read strobe and the ALU function that the datapath needs for that step. A bus-source enable places a value on the shared bus, and a load enable captures the bus into a register.

Every instruction starts with the same three-step fetch. The sequencer then reads the instruction register's mode and opcode fields and picks one of three operand sequences: immediate, direct or indirect. An unknown instruction takes a single terminating step that raises an error pulse. Any step that needs memory data holds until the memory signals that the data is ready. The current step number, an end-of-instruction strobe and a registered completion pulse are brought out so that the step count of each instruction can be observed.

Top module: `load_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `step_no` = 1 with every control output, `end_step`, `err` and `done` low. The first cycle after reset is released is also idle in this way. Step 1 begins the cycle after that.
- R2: Steps 1 to 3 are the same for every instruction. In step 1, `bus_pc_oe`, `mar_we`, `z_we` and `mem_rd` are high and `alu_op` = 2'b01 (add a constant). In step 2, `bus_z_oe`, `pc_we` and `y_we` are high. In step 3, `bus_mdr_oe` and `ir_we` are high. In all other steps `alu_op` is 2'b00.
- R3: Mode 2'b00 (immediate) with opcode `LOAD_OPC` ends at step 4, which raises `bus_iraddr_oe` and `rf_we`. The instruction takes 4 steps.
- R4: Mode 2'b01 (direct) works as follows. Step 4 raises `bus_iraddr_oe`, `mar_we` and `mem_rd`. Step 5 drives nothing and waits for memory. Step 6 raises `bus_mdr_oe` and `rf_we` and ends the instruction, which takes 6 steps.
- R5: Mode 2'b10 (indirect) works as follows. Step 4 is the same as in R4. Step 5 waits for memory. Step 6 raises `bus_mdr_oe`, `mar_we` and `mem_rd`. Step 7 waits for memory, raises `bus_mdr_oe` and `rf_we`, and ends the instruction, which takes 7 steps.
- R6: Mode 2'b11, or any opcode other than `LOAD_OPC`, makes step 4 a terminating step with no control outputs and with `end_step` and `err` high. `err` is high in no other cycle.
- R7: Steps 3, 5 (direct and indirect) and 7 wait for memory. While `mem_ready` is low in such a step, `step_no` and all control outputs stay unchanged. `mem_ready` has no effect in any other step.
- R8: At most one of the four bus-source enables is high in any cycle.
- R9: `end_step` is high only in the cycle in which the last step of an instruction completes. The next cycle shows `step_no` = 1 with `done` high, and `done` is low at all other times.
- R10: `step_no` always reports the number of the current step, from 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_opcode | input | OPC_W | Opcode field of the instruction register |
| ir_mode | input | 2 | Operand mode field of the instruction register |
| mem_ready | input | 1 | Memory data is available in the data register |
| bus_pc_oe | output | 1 | Drive the program counter onto the bus |
| bus_iraddr_oe | output | 1 | Drive the instruction's address/operand field onto the bus |
| bus_mdr_oe | output | 1 | Drive the memory data register onto the bus |
| bus_z_oe | output | 1 | Drive the ALU result register onto the bus |
| mar_we | output | 1 | Load the memory address register from the bus |
| ir_we | output | 1 | Load the instruction register from the bus |
| pc_we | output | 1 | Load the program counter from the bus |
| y_we | output | 1 | Load the ALU operand register from the bus |
| z_we | output | 1 | Load the ALU result register |
| rf_we | output | 1 | Write the bus into the destination register |
| mem_rd | output | 1 | Start a memory read at the address register |
| alu_op | output | 2 | ALU function: 00 none, 01 add constant |
| step_no | output | 3 | Current control step, 1 to 7 |
| end_step | output | 1 | Last step of the instruction completes this cycle |
| done | output | 1 | One-cycle pulse after an instruction ends |
| err | output | 1 | Unknown instruction ends in this step |

## Verification
The assertions assume that the instruction register fields hold steady from the end of step 3 until the instruction ends. They also assume that the datapath loads the register only when `ir_we` is high, because the stall check compares control outputs that depend on the mode. The stimulus respects this. The bench changes `ir_mode` and `ir_opcode` only in the cycle in which step 3 completes, and the outputs of step 3 do not depend on those fields. `mem_ready` arrives after a latency that differs from one instruction to the next. It is toggled freely in steps that do not wait, and one reset lands in the middle of an instruction.

// File: rtl/ldseq_pkg.sv
// Package: shared constants and types of the load sequencer.
// Assumes: at most seven control steps per instruction.
package ldseq_pkg;

    localparam int MAX_STEP = 7;
    localparam int STEP_W   = $clog2(MAX_STEP + 1);
    localparam int MODE_W   = 2;

    // bus source positions inside ctrl_t.src
    localparam int N_SRC   = 4;
    localparam int SRC_PC  = 0;
    localparam int SRC_IRA = 1;
    localparam int SRC_MDR = 2;
    localparam int SRC_Z   = 3;

    // load enable positions inside ctrl_t.ld
    localparam int N_LD   = 6;
    localparam int LD_MAR = 0;
    localparam int LD_IR  = 1;
    localparam int LD_PC  = 2;
    localparam int LD_Y   = 3;
    localparam int LD_Z   = 4;
    localparam int LD_RF  = 5;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM = 2'b00,
        AM_DIR = 2'b01,
        AM_IND = 2'b10,
        AM_BAD = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        PATH_IMM,
        PATH_DIR,
        PATH_IND,
        PATH_BAD
    } path_e;

    typedef enum logic [1:0] {
        ALU_NOP  = 2'b00,
        ALU_ADDK = 2'b01
    } alu_e;

    typedef struct packed {
        logic [N_SRC-1:0] src;
        logic [N_LD-1:0]  ld;
        logic             mem_rd;
        alu_e             alu;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  wait_mem;
        logic  last;
        logic  bad;
    } step_word_t;

endpackage

// File: rtl/ldseq_classify.sv
// Module: maps the instruction register fields to one operand path.
// Assumes: fields are meaningful only from step 4 onward.
module ldseq_classify
    import ldseq_pkg::*;
#(
    parameter int              OPC_W    = 4,
    parameter logic [OPC_W-1:0] LOAD_OPC = 4'h1
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [MODE_W-1:0] mode,
    output path_e             path
);

    // purpose: pick the operand path, unknown encodings go to PATH_BAD
    always_comb begin
        if (opcode != LOAD_OPC) begin
            path = PATH_BAD;
        end else begin
            case (amode_e'(mode))
                AM_IMM:  path = PATH_IMM;
                AM_DIR:  path = PATH_DIR;
                AM_IND:  path = PATH_IND;
                default: path = PATH_BAD;
            endcase
        end
    end

endmodule

// File: rtl/ldseq_decode.sv
// Module: combinational control word for the current step and path.
// Assumes: step is 1..MAX_STEP; unreachable step/path pairs end the
// instruction so the sequencer always recovers to step 1.
module ldseq_decode
    import ldseq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  path_e             path,
    input  logic              live,
    output step_word_t        word
);

    step_word_t raw;

    // purpose: build the raw control word of the step
    always_comb begin
        raw          = '0;
        raw.ctrl.alu = ALU_NOP;
        case (int'(step))
            1: begin
                raw.ctrl.src[SRC_PC] = 1'b1;
                raw.ctrl.ld[LD_MAR]  = 1'b1;
                raw.ctrl.ld[LD_Z]    = 1'b1;
                raw.ctrl.mem_rd      = 1'b1;
                raw.ctrl.alu         = ALU_ADDK;
            end
            2: begin
                raw.ctrl.src[SRC_Z] = 1'b1;
                raw.ctrl.ld[LD_PC]  = 1'b1;
                raw.ctrl.ld[LD_Y]   = 1'b1;
            end
            3: begin
                raw.ctrl.src[SRC_MDR] = 1'b1;
                raw.ctrl.ld[LD_IR]    = 1'b1;
                raw.wait_mem          = 1'b1;
            end
            4: begin
                case (path)
                    PATH_IMM: begin
                        raw.ctrl.src[SRC_IRA] = 1'b1;
                        raw.ctrl.ld[LD_RF]    = 1'b1;
                        raw.last              = 1'b1;
                    end
                    PATH_DIR, PATH_IND: begin
                        raw.ctrl.src[SRC_IRA] = 1'b1;
                        raw.ctrl.ld[LD_MAR]   = 1'b1;
                        raw.ctrl.mem_rd       = 1'b1;
                    end
                    default: begin
                        raw.last = 1'b1;
                        raw.bad  = 1'b1;
                    end
                endcase
            end
            5: begin
                if (path == PATH_DIR || path == PATH_IND) begin
                    raw.wait_mem = 1'b1;
                end else begin
                    raw.last = 1'b1;
                end
            end
            6: begin
                if (path == PATH_DIR) begin
                    raw.ctrl.src[SRC_MDR] = 1'b1;
                    raw.ctrl.ld[LD_RF]    = 1'b1;
                    raw.last              = 1'b1;
                end else if (path == PATH_IND) begin
                    raw.ctrl.src[SRC_MDR] = 1'b1;
                    raw.ctrl.ld[LD_MAR]   = 1'b1;
                    raw.ctrl.mem_rd       = 1'b1;
                end else begin
                    raw.last = 1'b1;
                end
            end
            7: begin
                if (path == PATH_IND) begin
                    raw.ctrl.src[SRC_MDR] = 1'b1;
                    raw.ctrl.ld[LD_RF]    = 1'b1;
                    raw.wait_mem          = 1'b1;
                end
                raw.last = 1'b1;
            end
            default: raw.last = 1'b1;
        endcase
    end

    // purpose: silence every output until the sequencer is live
    always_comb begin
        word = live ? raw : '0;
    end

endmodule

// File: rtl/ldseq_counter.sv
// Module: step counter with memory stall, restart and completion pulse.
// Assumes: synchronous active-low reset; live rises one cycle after release.
module ldseq_counter
    import ldseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_mem,
    input  logic              last,
    input  logic              mem_ready,
    output logic [STEP_W-1:0] step,
    output logic              live,
    output logic              go,
    output logic              done
);

    // purpose: a step completes unless it waits on memory that is not ready
    always_comb begin
        go = live && (!wait_mem || mem_ready);
    end

    // purpose: advance, restart or hold the step number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= STEP_W'(1);
            live <= 1'b0;
            done <= 1'b0;
        end else begin
            live <= 1'b1;
            done <= go && last;
            if (go) begin
                step <= last ? STEP_W'(1) : step + STEP_W'(1);
            end
        end
    end

endmodule

// File: rtl/load_seq.sv
// Module: top of the load instruction control sequencer.
// Assumes: ir_opcode/ir_mode hold steady from the end of step 3 to the
// end of the instruction.
module load_seq
    import ldseq_pkg::*;
#(
    parameter int               OPC_W    = 4,
    parameter logic [OPC_W-1:0] LOAD_OPC = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  ir_opcode,
    input  logic [MODE_W-1:0] ir_mode,
    input  logic              mem_ready,
    output logic              bus_pc_oe,
    output logic              bus_iraddr_oe,
    output logic              bus_mdr_oe,
    output logic              bus_z_oe,
    output logic              mar_we,
    output logic              ir_we,
    output logic              pc_we,
    output logic              y_we,
    output logic              z_we,
    output logic              rf_we,
    output logic              mem_rd,
    output logic [1:0]        alu_op,
    output logic [STEP_W-1:0] step_no,
    output logic              end_step,
    output logic              done,
    output logic              err
);

    path_e             path;
    step_word_t        word;
    logic [STEP_W-1:0] step_q;
    logic              live_q;
    logic              go;
    logic              done_q;

    ldseq_classify #(
        .OPC_W    (OPC_W),
        .LOAD_OPC (LOAD_OPC)
    ) u_class (
        .opcode (ir_opcode),
        .mode   (ir_mode),
        .path   (path)
    );

    ldseq_decode u_dec (
        .step (step_q),
        .path (path),
        .live (live_q),
        .word (word)
    );

    ldseq_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_mem  (word.wait_mem),
        .last      (word.last),
        .mem_ready (mem_ready),
        .step      (step_q),
        .live      (live_q),
        .go        (go),
        .done      (done_q)
    );

    // purpose: spread the control word onto the named ports
    always_comb begin
        bus_pc_oe     = word.ctrl.src[SRC_PC];
        bus_iraddr_oe = word.ctrl.src[SRC_IRA];
        bus_mdr_oe    = word.ctrl.src[SRC_MDR];
        bus_z_oe      = word.ctrl.src[SRC_Z];
        mar_we        = word.ctrl.ld[LD_MAR];
        ir_we         = word.ctrl.ld[LD_IR];
        pc_we         = word.ctrl.ld[LD_PC];
        y_we          = word.ctrl.ld[LD_Y];
        z_we          = word.ctrl.ld[LD_Z];
        rf_we         = word.ctrl.ld[LD_RF];
        mem_rd        = word.ctrl.mem_rd;
        alu_op        = word.ctrl.alu;
        step_no       = step_q;
        end_step      = word.last && go;
        err           = word.bad;
        done          = done_q;
    end

endmodule

// File: rtl/load_seq_checker.sv
// Module: property checker bound into load_seq.
// Assumes: instruction register fields stable between step 3 and the end.
module load_seq_checker
    import ldseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              live,
    input logic [MODE_W-1:0] ir_mode,
    input logic              mem_ready,
    input logic              bus_pc_oe,
    input logic              bus_iraddr_oe,
    input logic              bus_mdr_oe,
    input logic              bus_z_oe,
    input logic              mar_we,
    input logic              ir_we,
    input logic              pc_we,
    input logic              y_we,
    input logic              z_we,
    input logic              rf_we,
    input logic              mem_rd,
    input logic [1:0]        alu_op,
    input logic [STEP_W-1:0] step_no,
    input logic              end_step,
    input logic              done,
    input logic              err
);

    logic [3:0]  srcs;
    logic [11:0] ctl;
    logic        waiting;

    always_comb begin
        srcs    = {bus_z_oe, bus_mdr_oe, bus_iraddr_oe, bus_pc_oe};
        ctl     = {srcs, mar_we, ir_we, pc_we, y_we, z_we, rf_we, mem_rd, alu_op[0]};
        waiting = (step_no == STEP_W'(3))
               || (step_no == STEP_W'(5) && ir_mode != 2'b00)
               || (step_no == STEP_W'(7));
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (step_no == STEP_W'(1) && srcs == '0 && ctl == '0
                    && !end_step && !done && !err));

    a_r2_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        (live && step_no == STEP_W'(1)) |-> (bus_pc_oe && mar_we && mem_rd && alu_op == 2'b01));

    a_r6_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (end_step && step_no == STEP_W'(4)));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && waiting && !mem_ready) |=> ($stable(step_no) && $stable(ctl)));

    a_r8_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(srcs));

    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        end_step |=> (step_no == STEP_W'(1) && done));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step_no >= STEP_W'(1) && step_no <= STEP_W'(MAX_STEP)));

endmodule

bind load_seq load_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .live          (live_q),
    .ir_mode       (ir_mode),
    .mem_ready     (mem_ready),
    .bus_pc_oe     (bus_pc_oe),
    .bus_iraddr_oe (bus_iraddr_oe),
    .bus_mdr_oe    (bus_mdr_oe),
    .bus_z_oe      (bus_z_oe),
    .mar_we        (mar_we),
    .ir_we         (ir_we),
    .pc_we         (pc_we),
    .y_we          (y_we),
    .z_we          (z_we),
    .rf_we         (rf_we),
    .mem_rd        (mem_rd),
    .alu_op        (alu_op),
    .step_no       (step_no),
    .end_step      (end_step),
    .done          (done),
    .err           (err)
);

// File: tb/load_seq_test.sv
module load_seq_test;
    import ldseq_pkg::*;

    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] LOAD_OP    = 4'h1;
    localparam int         N_INSTR    = 20;
    localparam int         WATCHDOG   = 5000;

    // expected-word bit positions (bench's own encoding)
    localparam int E_SPC = 1 << 0, E_SIR = 1 << 1, E_SMDR = 1 << 2, E_SZ = 1 << 3;
    localparam int E_MAR = 1 << 4, E_IR = 1 << 5, E_PC = 1 << 6, E_Y = 1 << 7;
    localparam int E_Z = 1 << 8, E_RF = 1 << 9, E_RD = 1 << 10, E_ADD = 1 << 11;
    localparam int E_WAIT = 1 << 12, E_LAST = 1 << 13, E_BAD = 1 << 14;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst_n;
    logic [3:0] ir_opcode;
    logic [1:0] ir_mode;
    logic       mem_ready;
    logic bus_pc_oe, bus_iraddr_oe, bus_mdr_oe, bus_z_oe;
    logic mar_we, ir_we, pc_we, y_we, z_we, rf_we, mem_rd;
    logic [1:0] alu_op;
    logic [STEP_W-1:0] step_no;
    logic end_step, done, err;

    load_seq #(.OPC_W(4), .LOAD_OPC(LOAD_OP)) uut (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_mode(ir_mode),
        .mem_ready(mem_ready), .bus_pc_oe(bus_pc_oe), .bus_iraddr_oe(bus_iraddr_oe),
        .bus_mdr_oe(bus_mdr_oe), .bus_z_oe(bus_z_oe), .mar_we(mar_we), .ir_we(ir_we),
        .pc_we(pc_we), .y_we(y_we), .z_we(z_we), .rf_we(rf_we), .mem_rd(mem_rd),
        .alu_op(alu_op), .step_no(step_no), .end_step(end_step), .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_bad(logic [1:0] md, logic [3:0] op);
        return (md == 2'b11) || (op != LOAD_OP);
    endfunction

    // expected control word of a step, written from the requirements
    function automatic int expw(int s, logic [1:0] md, logic [3:0] op);
        bit bad = is_bad(md, op);
        if (s == 1) return E_SPC | E_MAR | E_RD | E_ADD | E_Z;
        if (s == 2) return E_SZ | E_PC | E_Y;
        if (s == 3) return E_SMDR | E_IR | E_WAIT;
        if (bad)    return (s == 4) ? (E_LAST | E_BAD) : 0;
        if (md == 2'b00) return (s == 4) ? (E_SIR | E_RF | E_LAST) : 0;
        if (s == 4) return E_SIR | E_MAR | E_RD;
        if (s == 5) return E_WAIT;
        if (md == 2'b01) return (s == 6) ? (E_SMDR | E_RF | E_LAST) : 0;
        if (s == 6) return E_SMDR | E_MAR | E_RD;
        if (s == 7) return E_SMDR | E_RF | E_WAIT | E_LAST;
        return 0;
    endfunction

    function automatic int steps_of(logic [1:0] md, logic [3:0] op);
        if (is_bad(md, op)) return 4;
        if (md == 2'b00) return 4;
        if (md == 2'b01) return 6;
        return 7;
    endfunction

    function automatic string tag_of(bit live, int s, logic [1:0] md, logic [3:0] op);
        if (!live) return "R1";
        if (s <= 3) return "R2";
        if (is_bad(md, op)) return "R6";
        if (md == 2'b00) return "R3";
        if (md == 2'b01) return "R4";
        return "R5";
    endfunction

    logic [1:0] prog_mode [N_INSTR];
    logic [3:0] prog_op   [N_INSTR];
    int         prog_lat  [N_INSTR];

    initial begin
        int  m_step = 1;
        bit  m_live = 0;
        bit  m_done = 0;
        int  idx = 0;
        int  cyc = 0;
        int  wcnt = 0;
        int  rst_left = 3;
        bit  did_mid = 0;
        bit  prev_stall = 0;
        int  e, act;
        bit  go, endc, waiting;
        string t;

        for (int i = 0; i < N_INSTR; i++) begin
            prog_mode[i] = 2'(i % 4);
            prog_op[i]   = (i % 7 == 5) ? 4'h6 : LOAD_OP;
            prog_lat[i]  = (i * 3) % 4;
        end

        rst_n = 1'b0; mem_ready = 1'b0; ir_mode = 2'b00; ir_opcode = 4'h0;

        while (idx < N_INSTR && cyc <= WATCHDOG) begin
            @(negedge clk);
            cyc++;
            e   = m_live ? expw(m_step, ir_mode, ir_opcode) : 0;
            act = (bus_pc_oe ? E_SPC : 0) | (bus_iraddr_oe ? E_SIR : 0)
                | (bus_mdr_oe ? E_SMDR : 0) | (bus_z_oe ? E_SZ : 0)
                | (mar_we ? E_MAR : 0) | (ir_we ? E_IR : 0) | (pc_we ? E_PC : 0)
                | (y_we ? E_Y : 0) | (z_we ? E_Z : 0) | (rf_we ? E_RF : 0)
                | (mem_rd ? E_RD : 0) | ((alu_op == 2'b01) ? E_ADD : 0)
                | ((alu_op[1]) ? 32'h8000 : 0);
            t = tag_of(m_live, m_step, ir_mode, ir_opcode);
            check(act == (e & 32'h0FFF), prev_stall ? "R7" : t, "controls", act, e & 32'h0FFF);
            check(int'(step_no) == m_step, prev_stall ? "R7" : (m_live ? "R10" : "R1"),
                  "step_no", int'(step_no), m_step);
            check($countones({bus_pc_oe, bus_iraddr_oe, bus_mdr_oe, bus_z_oe}) <= 1,
                  "R8", "bus sources", act & 15, 1);
            check(done == m_done, m_live ? "R9" : "R1", "done", int'(done), int'(m_done));

            // reset schedule, including one reset in the middle of a direct load
            if (!did_mid && idx == 9 && m_step == 5 && m_live) begin
                rst_left = 2;
                did_mid  = 1;
            end
            if (rst_left > 0) begin
                rst_left--;
                rst_n = 1'b0;
            end else begin
                rst_n = 1'b1;
            end

            waiting = m_live && ((e & E_WAIT) != 0);
            if (waiting) mem_ready = (wcnt >= prog_lat[idx]);
            else         mem_ready = cyc[0];
            #1;

            go   = m_live && (!waiting || mem_ready);
            endc = go && ((e & E_LAST) != 0);
            check(end_step == endc, "R9", "end_step", int'(end_step), int'(endc));
            check(err == (m_live && (e & E_BAD) != 0), "R6", "err", int'(err),
                  int'(m_live && (e & E_BAD) != 0));
            if (endc && rst_n) begin
                check(m_step == steps_of(ir_mode, ir_opcode), tag_of(1, 4, ir_mode, ir_opcode),
                      "step count", m_step, steps_of(ir_mode, ir_opcode));
            end

            prev_stall = rst_n && waiting && !mem_ready;
            if (waiting && !mem_ready) wcnt++;
            else                       wcnt = 0;

            if (m_step == 3 && go && rst_n) begin
                ir_mode   = prog_mode[idx];
                ir_opcode = prog_op[idx];
            end

            if (!rst_n) begin
                m_step = 1; m_live = 0; m_done = 0; wcnt = 0;
            end else begin
                m_live = 1;
                m_done = endc;
                if (go) m_step = ((e & E_LAST) != 0) ? 1 : m_step + 1;
                if (endc) idx++;
            end
        end

        if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule